// File: doc/BRIEF.md
# BCD Real-Time Clock Register Block

This block keeps calendar time of day in binary-coded decimal and shows it to software as eight byte-wide registers. The registers sit at the top of an address window. They are, in ascending address order: a control byte, seconds, minutes, hours, weekday with a century flag, date of month, month and year. A one-cycle pulse on the 1 Hz input advances the time by one second. The carry runs through minutes, hours, days, months and years. Month lengths are taken into account, with a leap February every fourth year.

Software sets the time by writing single registers. Each write is range-checked against its field. A value outside the field's range is dropped, and that register and the running time stay unchanged. Bit 7 of the seconds register is a stop flag. While it is set, ticks are ignored and the time stays frozen. Clearing it lets counting go on from the value that was held. The year register counts 00 to 99. A build-time bias gives the calendar year that register value 00 stands for, so one variant can count years from a 1968 base and still place its leap years correctly. The full time is also driven out continuously on a BCD bus for an alarm comparator.

Top module: `rtc_bcd_regs`

## Requirements
- R1: After reset the registers hold control 0x00, seconds 0x00 with the stop flag clear, minutes 0x00, hours 0x00, weekday 0 with century clear, date 0x01, month 0x01 and year 0x00.
- R2: The registers sit at BASE_ADDR+0 (control), +1 (seconds), +2 (minutes), +3 (hours), +4 (weekday/century), +5 (date), +6 (month) and +7 (year). A read of any other address returns 0xFF.
- R3: A write to the control register stores the written byte with bits 7 and 5 cleared and then bits 7 and 4 set. A read returns that stored byte.
- R4: Each tick while not stopped adds one BCD second. Seconds go from 59 to 00 and carry into minutes. Minutes go from 59 to 00 and carry into hours. Hours go from 23 to 00 and carry into the day.
- R5: At each day carry the weekday advances modulo 7 (6 wraps to 0). A date equal to the month's length goes back to 01 and advances the month. April, June, September and November have 30 days, February has 28 or 29, and the other months have 31.
- R6: February has 29 days when (binary year register + YEAR_BIAS) is a multiple of 4, and 28 days otherwise.
- R7: A day carry out of month 12 sets the month to 01 and advances the year. Year 99 wraps to 00.
- R8: A seconds write takes bits [6:0] as BCD seconds and bit 7 as the stop flag. It is accepted only when bits [6:0] are valid BCD 00..59. A seconds read returns the stop flag in bit 7 and the BCD seconds in bits [6:0].
- R9: While the stop flag is 1, ticks leave all time fields unchanged. After the flag is written back to 0, the next tick advances from the held value.
- R10: Writes are accepted only within these ranges: minutes 00..59 (bits [6:0]), hours 00..23 (bits [5:0]), date 01..31 (bits [5:0]), month 01..12 (bits [4:0]), year 00..99 (all 8 bits, valid BCD) and weekday 0..6 (bits [2:0]). Bits outside a field are ignored. A rejected write leaves every register unchanged.
- R11: The weekday register stores bit 6 as a century flag and bits [2:0] as the weekday. A read returns the century flag in bit 6, the weekday in bits [2:0] and zero in the other bits.
- R12: The time bus outputs always equal the register contents of the same fields, and clk_stopped equals the stop flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Byte write strobe |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| tm_sec | output | 7 | BCD seconds |
| tm_min | output | 7 | BCD minutes |
| tm_hour | output | 6 | BCD hours |
| tm_wday | output | 3 | Weekday 0..6 |
| tm_date | output | 6 | BCD date of month |
| tm_mon | output | 5 | BCD month |
| tm_year | output | 8 | BCD year register |
| clk_stopped | output | 1 | Stop flag state |

## Verification
The bench keeps ADDR_W at 13 and BASE_ADDR at 0x1FF8, so the registers fill the last eight bytes of the window and an address just below them returns 0xFF. It sets YEAR_BIAS to 68, which is the 1968-based year variant. Register year 32 is then a leap year and year 33 is not. This lets the bench check the bias path of the leap test against known calendar years, in addition to the month-length carries, the December to January wrap, the year wrap from 99, the stop-and-resume sequence and every range rejection.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef struct packed {
        logic       stop;
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hour;
        logic       cent;
        logic [2:0] wday;
        logic [5:0] date;
        logic [4:0] mon;
        logic [7:0] year;
    } rtc_time_t;

    typedef struct packed {
        logic ctrl;
        logic sec;
        logic min;
        logic hour;
        logic wday;
        logic date;
        logic mon;
        logic year;
    } rtc_ld_t;

    typedef enum logic [2:0] {
        RG_CTRL = 3'd0,
        RG_SEC  = 3'd1,
        RG_MIN  = 3'd2,
        RG_HOUR = 3'd3,
        RG_WDAY = 3'd4,
        RG_DATE = 3'd5,
        RG_MON  = 3'd6,
        RG_YEAR = 3'd7
    } rtc_reg_e;

    localparam int NUM_REGS = 8;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    function automatic logic bcd_ok(input logic [7:0] v);
        return (v[7:4] <= 4'd9) && (v[3:0] <= 4'd9);
    endfunction

    function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
        return ({3'b000, v[7:4]} * 7'd10) + {3'b000, v[3:0]};
    endfunction

    // Month length as a BCD day count
    function automatic logic [5:0] month_len(input logic [4:0] mon, input logic leap);
        logic [5:0] r;
        case (mon)
            5'h02:                      r = leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: r = 6'h30;
            default:                    r = 6'h31;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rtc_wr_decode.sv
module rtc_wr_decode
    import rtc_pkg::*;
#(
    parameter int              ADDR_W    = 13,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 13'h1FF8
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic              hit,
    output logic [2:0]        idx,
    output rtc_ld_t           ld
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = BASE_ADDR + ADDR_W'(NUM_REGS - 1);

    logic [ADDR_W-1:0]   offs;
    logic [NUM_REGS-1:0] fld_ok;
    logic [NUM_REGS-1:0] fld_sel;

    assign offs = addr - BASE_ADDR;
    assign hit  = (addr >= BASE_ADDR) && (addr <= LAST_ADDR);
    assign idx  = offs[2:0];

    always_comb begin
        fld_ok          = '0;
        fld_ok[RG_CTRL] = 1'b1;
        fld_ok[RG_SEC]  = bcd_ok({1'b0, wdata[6:0]}) && (wdata[6:4] <= 3'd5);
        fld_ok[RG_MIN]  = bcd_ok({1'b0, wdata[6:0]}) && (wdata[6:4] <= 3'd5);
        fld_ok[RG_HOUR] = bcd_ok({2'b00, wdata[5:0]}) && (wdata[5:0] <= 6'h23);
        fld_ok[RG_WDAY] = (wdata[2:0] <= 3'd6);
        fld_ok[RG_DATE] = bcd_ok({2'b00, wdata[5:0]}) && (wdata[5:0] >= 6'h01)
                          && (wdata[5:0] <= 6'h31);
        fld_ok[RG_MON]  = bcd_ok({3'b000, wdata[4:0]}) && (wdata[4:0] >= 5'h01)
                          && (wdata[4:0] <= 5'h12);
        fld_ok[RG_YEAR] = bcd_ok(wdata);
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
        assign fld_sel[g] = wr_en && hit && (idx == 3'(g)) && fld_ok[g];
    end

    always_comb begin
        ld      = '0;
        ld.ctrl = fld_sel[RG_CTRL];
        ld.sec  = fld_sel[RG_SEC];
        ld.min  = fld_sel[RG_MIN];
        ld.hour = fld_sel[RG_HOUR];
        ld.wday = fld_sel[RG_WDAY];
        ld.date = fld_sel[RG_DATE];
        ld.mon  = fld_sel[RG_MON];
        ld.year = fld_sel[RG_YEAR];
    end

endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_pkg::*;
#(
    parameter int YEAR_BIAS = 0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  rtc_ld_t   ld,
    input  logic [7:0] wdata,
    output rtc_time_t time_q
);
    localparam logic [1:0] BIAS_MOD4 = 2'(YEAR_BIAS % 4);

    rtc_time_t t_d, t_q;
    logic [6:0] yr_bin;
    logic       leap;
    logic [5:0] mlen;
    logic [7:0] sec_nx, min_nx, hour_nx, date_nx, mon_nx, year_nx;

    assign yr_bin  = bcd_to_bin(t_q.year);
    assign leap    = ((yr_bin[1:0] + BIAS_MOD4) == 2'b00);
    assign mlen    = month_len(t_q.mon, leap);
    assign sec_nx  = bcd_inc({1'b0, t_q.sec});
    assign min_nx  = bcd_inc({1'b0, t_q.min});
    assign hour_nx = bcd_inc({2'b00, t_q.hour});
    assign date_nx = bcd_inc({2'b00, t_q.date});
    assign mon_nx  = bcd_inc({3'b000, t_q.mon});
    assign year_nx = bcd_inc(t_q.year);

    always_comb begin
        t_d = t_q;
        if (tick && !t_q.stop) begin
            if (t_q.sec != 7'h59) begin
                t_d.sec = sec_nx[6:0];
            end else begin
                t_d.sec = 7'h00;
                if (t_q.min != 7'h59) begin
                    t_d.min = min_nx[6:0];
                end else begin
                    t_d.min = 7'h00;
                    if (t_q.hour != 6'h23) begin
                        t_d.hour = hour_nx[5:0];
                    end else begin
                        t_d.hour = 6'h00;
                        t_d.wday = (t_q.wday >= 3'd6) ? 3'd0 : t_q.wday + 3'd1;
                        if (t_q.date < mlen) begin
                            t_d.date = date_nx[5:0];
                        end else begin
                            t_d.date = 6'h01;
                            if (t_q.mon != 5'h12) begin
                                t_d.mon = mon_nx[4:0];
                            end else begin
                                t_d.mon  = 5'h01;
                                t_d.year = (t_q.year == 8'h99) ? 8'h00 : year_nx;
                            end
                        end
                    end
                end
            end
        end
        // accepted writes override the tick result for their field
        if (ld.sec) begin
            t_d.sec  = wdata[6:0];
            t_d.stop = wdata[7];
        end
        if (ld.min)  t_d.min  = wdata[6:0];
        if (ld.hour) t_d.hour = wdata[5:0];
        if (ld.wday) begin
            t_d.wday = wdata[2:0];
            t_d.cent = wdata[6];
        end
        if (ld.date) t_d.date = wdata[5:0];
        if (ld.mon)  t_d.mon  = wdata[4:0];
        if (ld.year) t_d.year = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q      <= '0;
            t_q.date <= 6'h01;
            t_q.mon  <= 5'h01;
        end else begin
            t_q <= t_d;
        end
    end

    assign time_q = t_q;

    // R4
    sec_bcd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.sec[3:0] <= 4'd9) && (t_q.sec[6:4] <= 3'd5));

    // R4
    sec_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !t_q.stop && (ld == '0)) |=> (t_q.sec != $past(t_q.sec)));

    // R9
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.stop && (ld == '0)) |=> $stable(t_q));

    // R5
    cal_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.date >= 6'h01) && (t_q.date <= 6'h31) && (t_q.mon >= 5'h01)
        && (t_q.mon <= 5'h12) && (t_q.wday <= 3'd6));

    // R10
    hour_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld.hour |=> (t_q.hour <= 6'h23));

endmodule

// File: rtl/rtc_bcd_regs.sv
module rtc_bcd_regs
    import rtc_pkg::*;
#(
    parameter int                ADDR_W    = 13,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 13'h1FF8,
    parameter int                YEAR_BIAS = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic [6:0]        tm_sec,
    output logic [6:0]        tm_min,
    output logic [5:0]        tm_hour,
    output logic [2:0]        tm_wday,
    output logic [5:0]        tm_date,
    output logic [4:0]        tm_mon,
    output logic [7:0]        tm_year,
    output logic              clk_stopped
);
    localparam logic [7:0] CTRL_CLR = 8'hA0;
    localparam logic [7:0] CTRL_SET = 8'h90;

    logic      hit;
    logic [2:0] idx;
    rtc_ld_t   ld;
    rtc_time_t tq;
    logic [7:0] ctrl_d, ctrl_q;

    rtc_wr_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .hit   (hit),
        .idx   (idx),
        .ld    (ld)
    );

    rtc_time_core #(.YEAR_BIAS(YEAR_BIAS)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_1hz),
        .ld     (ld),
        .wdata  (wdata),
        .time_q (tq)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        if (ld.ctrl) ctrl_d = (wdata & ~CTRL_CLR) | CTRL_SET;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= 8'h00;
        else        ctrl_q <= ctrl_d;
    end

    always_comb begin
        rdata = 8'hFF;
        if (hit) begin
            case (rtc_reg_e'(idx))
                RG_CTRL: rdata = ctrl_q;
                RG_SEC:  rdata = {tq.stop, tq.sec};
                RG_MIN:  rdata = {1'b0, tq.min};
                RG_HOUR: rdata = {2'b00, tq.hour};
                RG_WDAY: rdata = {1'b0, tq.cent, 3'b000, tq.wday};
                RG_DATE: rdata = {2'b00, tq.date};
                RG_MON:  rdata = {3'b000, tq.mon};
                RG_YEAR: rdata = tq.year;
                default: rdata = 8'hFF;
            endcase
        end
    end

    assign tm_sec      = tq.sec;
    assign tm_min      = tq.min;
    assign tm_hour     = tq.hour;
    assign tm_wday     = tq.wday;
    assign tm_date     = tq.date;
    assign tm_mon      = tq.mon;
    assign tm_year     = tq.year;
    assign clk_stopped = tq.stop;

    // R3
    ctrl_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld.ctrl |=> (ctrl_q[7] && ctrl_q[4] && !ctrl_q[5]));

    // R2
    unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (rdata == 8'hFF));

endmodule

// File: tb/tb_rtc_bcd_regs.sv
module tb_rtc_bcd_regs;
    localparam int          AW   = 13;
    localparam logic [AW-1:0] BASE = 13'h1FF8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_1hz = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic [6:0]    tm_sec, tm_min;
    logic [5:0]    tm_hour, tm_date;
    logic [2:0]    tm_wday;
    logic [4:0]    tm_mon;
    logic [7:0]    tm_year;
    logic          clk_stopped;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rtc_bcd_regs #(.ADDR_W(AW), .BASE_ADDR(BASE), .YEAR_BIAS(68)) dut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .tm_sec(tm_sec),
        .tm_min(tm_min), .tm_hour(tm_hour), .tm_wday(tm_wday),
        .tm_date(tm_date), .tm_mon(tm_mon), .tm_year(tm_year),
        .clk_stopped(clk_stopped)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] off, input logic [7:0] d);
        @(negedge clk);
        addr = BASE + AW'(off); wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] off, output logic [7:0] v);
        @(negedge clk);
        addr = BASE + AW'(off);
        #1 v = rdata;
    endtask

    task automatic rchk(input string tag, input logic [2:0] off, input logic [7:0] exp);
        logic [7:0] v;
        rd(off, v);
        chk(tag, v, exp);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_1hz = 1'b1;
            @(negedge clk); tick_1hz = 1'b0;
        end
    endtask

    task automatic set_time(input logic [7:0] y, input logic [7:0] mo, input logic [7:0] d,
                            input logic [7:0] wd, input logic [7:0] h, input logic [7:0] mi,
                            input logic [7:0] s);
        wr(7, y); wr(6, mo); wr(5, d); wr(4, wd); wr(3, h); wr(2, mi); wr(1, s);
    endtask

    task automatic t_reset;
        rchk("R1 ctrl", 0, 8'h00); rchk("R1 sec", 1, 8'h00);
        rchk("R1 min", 2, 8'h00);  rchk("R1 hour", 3, 8'h00);
        rchk("R1 wday", 4, 8'h00); rchk("R1 date", 5, 8'h01);
        rchk("R1 mon", 6, 8'h01);  rchk("R1 year", 7, 8'h00);
    endtask

    task automatic t_map;
        logic [7:0] v;
        @(negedge clk); addr = BASE - 1; #1 v = rdata;
        chk("R2 below window", v, 8'hFF);
        @(negedge clk); addr = '0; #1 v = rdata;
        chk("R2 address zero", v, 8'hFF);
    endtask

    task automatic t_ctrl;
        wr(0, 8'hFF); rchk("R3 ctrl FF", 0, 8'hDF);
        wr(0, 8'h00); rchk("R3 ctrl 00", 0, 8'h90);
        wr(0, 8'h2A); rchk("R3 ctrl 2A", 0, 8'h9A);
    endtask

    task automatic t_carry;
        set_time(8'h10, 8'h05, 8'h14, 8'h02, 8'h09, 8'h59, 8'h58);
        tick(1); rchk("R4 sec inc", 1, 8'h59);
        tick(1); rchk("R4 sec wrap", 1, 8'h00);
        rchk("R4 min carry", 2, 8'h00); rchk("R4 hour carry", 3, 8'h10);
        wr(2, 8'h09); wr(1, 8'h59); tick(1);
        rchk("R4 min digit", 2, 8'h10);
        chk("R12 bus hour", {2'b0, tm_hour}, 8'h10);
        chk("R12 bus min", {1'b0, tm_min}, 8'h10);
    endtask

    task automatic t_days;
        set_time(8'h33, 8'h04, 8'h30, 8'h06, 8'h23, 8'h59, 8'h59);
        tick(1);
        rchk("R5 30-day month", 5, 8'h01); rchk("R5 month adv", 6, 8'h05);
        rchk("R5 wday wrap", 4, 8'h00);    rchk("R4 hour wrap", 3, 8'h00);
        set_time(8'h33, 8'h05, 8'h30, 8'h03, 8'h23, 8'h59, 8'h59);
        tick(1);
        rchk("R5 31-day month", 5, 8'h31); rchk("R5 wday inc", 4, 8'h04);
    endtask

    task automatic t_leap;
        set_time(8'h32, 8'h02, 8'h28, 8'h06, 8'h23, 8'h59, 8'h58);
        tick(2);
        rchk("R6 leap feb 29", 5, 8'h29); rchk("R6 leap month", 6, 8'h02);
        wr(3, 8'h23); wr(2, 8'h59); wr(1, 8'h59); tick(1);
        rchk("R6 leap mar 1", 5, 8'h01); rchk("R6 leap mar", 6, 8'h03);
        set_time(8'h33, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
        tick(1);
        rchk("R6 common mar 1", 5, 8'h01); rchk("R6 common mar", 6, 8'h03);
    endtask

    task automatic t_year;
        set_time(8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
        tick(1);
        rchk("R7 year wrap", 7, 8'h00); rchk("R7 month wrap", 6, 8'h01);
        rchk("R7 date", 5, 8'h01);
        set_time(8'h45, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
        tick(1);
        rchk("R7 year inc", 7, 8'h46);
        chk("R12 bus year", tm_year, 8'h46);
    endtask

    task automatic t_stop;
        wr(2, 8'h30);
        wr(1, 8'h92);
        rchk("R8 stop read", 1, 8'h92);
        chk("R12 stopped pin", {7'b0, clk_stopped}, 8'h01);
        tick(3);
        rchk("R9 frozen sec", 1, 8'h92); rchk("R9 frozen min", 2, 8'h30);
        wr(1, 8'h12);
        rchk("R9 unstop", 1, 8'h12);
        tick(1);
        rchk("R9 resume", 1, 8'h13);
        wr(1, 8'h65); rchk("R8 sec reject", 1, 8'h13);
        wr(1, 8'h4B); rchk("R8 sec bad digit", 1, 8'h13);
        chk("R8 stop kept clear", {7'b0, clk_stopped}, 8'h00);
    endtask

    task automatic t_reject;
        set_time(8'h21, 8'h07, 8'h15, 8'h03, 8'h11, 8'h22, 8'h33);
        wr(2, 8'h60); rchk("R10 min 60", 2, 8'h22);
        wr(2, 8'h5A); rchk("R10 min digit", 2, 8'h22);
        wr(3, 8'h24); rchk("R10 hour 24", 3, 8'h11);
        wr(3, 8'hD5); rchk("R10 hour mask", 3, 8'h15);
        wr(5, 8'h00); rchk("R10 date 0", 5, 8'h15);
        wr(5, 8'h32); rchk("R10 date 32", 5, 8'h15);
        wr(6, 8'h00); rchk("R10 mon 0", 6, 8'h07);
        wr(6, 8'h13); rchk("R10 mon 13", 6, 8'h07);
        wr(6, 8'hE9); rchk("R10 mon mask", 6, 8'h09);
        wr(7, 8'h9A); rchk("R10 year digit", 7, 8'h21);
        wr(4, 8'h47); rchk("R10 wday 7", 4, 8'h03);
        rchk("R10 sec untouched", 1, 8'h33);
    endtask

    task automatic t_century;
        wr(4, 8'h45); rchk("R11 cent set", 4, 8'h45);
        wr(4, 8'hBA); rchk("R11 cent clear", 4, 8'h02);
        chk("R12 bus wday", {5'b0, tm_wday}, 8'h02);
    endtask

    initial begin
        #1500000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_map;
        t_ctrl;
        t_carry;
        t_days;
        t_leap;
        t_year;
        t_stop;
        t_reject;
        t_century;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule